// File: doc/BRIEF.md
# Mixed-Sign Byte Dot-Product Accumulator

This block is a SIMD arithmetic stage for integer inference kernels. Three wide operands arrive together: a vector of unsigned bytes, a vector of signed bytes and a vector of 32-bit accumulators. Every 32-bit lane forms the four byte products inside its own slice, adds them to its accumulator, and then either keeps the low 32 bits of the sum or clamps it to the signed 32-bit range.

A per-lane predicate decides what each lane returns. A lane with its predicate set returns the new sum. A lane with its predicate clear returns either its incoming accumulator (merge) or zero (zeroing), and a mode input picks between those two. A width control narrows the operation to the lower half of the lanes. Operands are taken on a qualified cycle and the answer is registered one clock later.

Top module: `mixdot_acc_unit`

## Requirements
- R1: Lane j (j = 0 at the least significant end) reads only bits [32j+31:32j] of each operand, so a change in one lane's operand bytes does not alter any other lane's result.
- R2: Each product takes a byte of `op_u` as unsigned (0..255) and the matching byte of `op_s` as two's-complement (-128..127). The lane result is the signed accumulator lane of `acc_in` plus the four products.
- R3: With `sat_en` = 0 the lane result is the low 32 bits of the exact sum, so it wraps modulo 2^32.
- R4: With `sat_en` = 1 an exact sum above 0x7FFFFFFF returns 0x7FFFFFFF and an exact sum below -2^31 returns 0x80000000. Any sum inside the range is returned unchanged, including one that lands exactly on a bound.
- R5: In an active lane whose `lane_en` bit is 0 with `zero_fill` = 0, the result is that lane of `acc_in`.
- R6: In an active lane whose `lane_en` bit is 0 with `zero_fill` = 1, the result is zero.
- R7: In an active lane whose `lane_en` bit is 1, the result is the computed value for either setting of `zero_fill`.
- R8: With `half_mode` = 1 only lanes 0..LANES/2-1 are active. Result bits from lane LANES/2 upward are zero, and the upper `lane_en` bits have no effect.
- R9: Operands are captured at a rising edge where `in_valid` = 1, and `result` and `out_valid` = 1 appear after that edge. After an edge with `in_valid` = 0, `out_valid` is 0 and `result` keeps its previous value.
- R10: A synchronous reset (`rst` = 1 at a rising edge) clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on this cycle are to be processed |
| half_mode | input | 1 | 1: only the lower half of the lanes is active |
| sat_en | input | 1 | 1: clamp each lane to the signed 32-bit range; 0: wrap |
| zero_fill | input | 1 | For predicated-off lanes: 1 gives zero, 0 gives the old accumulator |
| lane_en | input | LANES | Per-lane predicate, bit j for lane j |
| acc_in | input | LANES*32 | Accumulator lanes |
| op_u | input | LANES*32 | Unsigned byte operand |
| op_s | input | LANES*32 | Signed byte operand |
| out_valid | output | 1 | Result register holds a fresh answer |
| result | output | LANES*32 | Registered lane results |

## Verification
Any fault in a lane's product sum, its overflow detection or its predicate choice shows up in that lane's slice of `result` on the first cycle after the qualifying edge, and nowhere else. That is why each directed case compares every lane separately with a model computed in the bench. The overflow flags inside each lane are brought out so that a wrong clamp is caught in the same cycle it forms, before it reaches the register. A fault in the capture path shows as `out_valid` disagreeing with the previous cycle's `in_valid`, or as `result` changing on an idle cycle. The bench looks for both one cycle after each issue.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;

  localparam int BYTE_W = 8;
  localparam int PROD_W = 2 * BYTE_W;

  // What a lane drives into the result register.
  typedef enum logic [1:0] {
    PICK_NEW  = 2'd0,
    PICK_OLD  = 2'd1,
    PICK_ZERO = 2'd2
  } pick_e;

  // Unsigned byte times signed byte; the product always fits PROD_W signed.
  function automatic logic signed [PROD_W-1:0] mul_u_by_s(
    input logic [BYTE_W-1:0] ua,
    input logic [BYTE_W-1:0] sb
  );
    logic signed [PROD_W-1:0] ze;
    logic signed [PROD_W-1:0] se;
    ze = signed'({{BYTE_W{1'b0}}, ua});
    se = signed'({{BYTE_W{sb[BYTE_W-1]}}, sb});
    return ze * se;
  endfunction

  // Choice for one lane from its activity, predicate and fill mode.
  function automatic pick_e pick_of(
    input logic active,
    input logic keep,
    input logic zero_mode
  );
    if (!active) return PICK_ZERO;
    if (keep) return PICK_NEW;
    return zero_mode ? PICK_ZERO : PICK_OLD;
  endfunction

endpackage

// File: rtl/dotacc_lane.sv
module dotacc_lane
  import dotacc_pkg::*;
#(
  parameter int ELEMS = 4,
  parameter int ACC_W = 32
) (
  input  logic [ELEMS*BYTE_W-1:0] a_grp,
  input  logic [ELEMS*BYTE_W-1:0] b_grp,
  input  logic [ACC_W-1:0]        acc,
  input  logic                    sat_en,
  output logic [ACC_W-1:0]        val,
  output logic                    ovf_pos,
  output logic                    ovf_neg
);

  localparam int GROW   = $clog2(ELEMS) + 2;
  localparam int WIDE_W = ACC_W + GROW;
  localparam int TOP_W  = WIDE_W - ACC_W + 1;

  logic signed [PROD_W-1:0] prods [ELEMS];
  logic signed [WIDE_W-1:0] wide;
  logic [TOP_W-1:0]         top_bits;
  logic                     fits;

  generate
    for (genvar g = 0; g < ELEMS; g++) begin : g_mul
      assign prods[g] = mul_u_by_s(a_grp[g*BYTE_W +: BYTE_W],
                                   b_grp[g*BYTE_W +: BYTE_W]);
    end
  endgenerate

  // Exact sum, wide enough that no intermediate can overflow.
  always_comb begin
    wide = WIDE_W'(signed'(acc));
    for (int k = 0; k < ELEMS; k++) begin
      wide = wide + WIDE_W'(prods[k]);
    end
  end

  // The sum fits ACC_W signed when every bit from ACC_W-1 upward agrees.
  assign top_bits = wide[WIDE_W-1:ACC_W-1];
  assign fits     = (&top_bits) | ~(|top_bits);
  assign ovf_pos  = !fits && !wide[WIDE_W-1];
  assign ovf_neg  = !fits &&  wide[WIDE_W-1];

  always_comb begin
    if (sat_en && ovf_pos)      val = {1'b0, {(ACC_W-1){1'b1}}};
    else if (sat_en && ovf_neg) val = {1'b1, {(ACC_W-1){1'b0}}};
    else                        val = wide[ACC_W-1:0];
  end

endmodule

// File: rtl/dotacc_pick.sv
module dotacc_pick
  import dotacc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int ACC_W = 32
) (
  input  logic [LANES*ACC_W-1:0] fresh,
  input  logic [LANES*ACC_W-1:0] old,
  input  logic [LANES-1:0]       lane_en,
  input  logic                   half_mode,
  input  logic                   zero_fill,
  output logic [LANES*ACC_W-1:0] chosen
);

  localparam int HALF = LANES / 2;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic  active;
      pick_e sel;
      if (g < HALF) begin : g_low
        assign active = 1'b1;
      end else begin : g_high
        assign active = !half_mode;
      end
      assign sel = pick_of(active, lane_en[g], zero_fill);
      always_comb begin
        case (sel)
          PICK_NEW: chosen[g*ACC_W +: ACC_W] = fresh[g*ACC_W +: ACC_W];
          PICK_OLD: chosen[g*ACC_W +: ACC_W] = old[g*ACC_W +: ACC_W];
          default:  chosen[g*ACC_W +: ACC_W] = '0;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/mixdot_acc_unit.sv
module mixdot_acc_unit
  import dotacc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int ELEMS = 4,
  parameter int ACC_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   half_mode,
  input  logic                   sat_en,
  input  logic                   zero_fill,
  input  logic [LANES-1:0]       lane_en,
  input  logic [LANES*ACC_W-1:0] acc_in,
  input  logic [LANES*ACC_W-1:0] op_u,
  input  logic [LANES*ACC_W-1:0] op_s,
  output logic                   out_valid,
  output logic [LANES*ACC_W-1:0] result
);

  localparam int DATA_W = LANES * ACC_W;
  localparam int GRP_W  = ELEMS * BYTE_W;

  // Internal events brought out for the bound checker.
  logic [DATA_W-1:0] lane_raw;
  logic [LANES-1:0]  ovf_pos_v;
  logic [LANES-1:0]  ovf_neg_v;
  logic [DATA_W-1:0] next_result;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      dotacc_lane #(
        .ELEMS(ELEMS),
        .ACC_W(ACC_W)
      ) u_lane (
        .a_grp  (op_u[g*GRP_W +: GRP_W]),
        .b_grp  (op_s[g*GRP_W +: GRP_W]),
        .acc    (acc_in[g*ACC_W +: ACC_W]),
        .sat_en (sat_en),
        .val    (lane_raw[g*ACC_W +: ACC_W]),
        .ovf_pos(ovf_pos_v[g]),
        .ovf_neg(ovf_neg_v[g])
      );
    end
  endgenerate

  dotacc_pick #(
    .LANES(LANES),
    .ACC_W(ACC_W)
  ) u_pick (
    .fresh    (lane_raw),
    .old      (acc_in),
    .lane_en  (lane_en),
    .half_mode(half_mode),
    .zero_fill(zero_fill),
    .chosen   (next_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_result;
    end
  end

endmodule

// File: rtl/dotacc_chk.sv
module dotacc_chk #(
  parameter int LANES = 8,
  parameter int ACC_W = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   half_mode,
  input logic                   sat_en,
  input logic                   zero_fill,
  input logic [LANES-1:0]       lane_en,
  input logic [LANES*ACC_W-1:0] acc_in,
  input logic [LANES*ACC_W-1:0] lane_raw,
  input logic [LANES-1:0]       ovf_pos_v,
  input logic [LANES-1:0]       ovf_neg_v,
  input logic                   out_valid,
  input logic [LANES*ACC_W-1:0] result
);

  localparam int DATA_W = LANES * ACC_W;
  localparam int HALF   = LANES / 2;
  localparam logic [ACC_W-1:0] TOPV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] BOTV = {1'b1, {(ACC_W-1){1'b0}}};

  // R9: handshake and hold
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_idle_clears: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // R8: upper half is zero in half mode
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    in_valid && half_mode |=> result[DATA_W-1:HALF*ACC_W] == '0);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      // R4: a sum cannot overflow both ways, and a clamp picks the bound
      a_r4_one_side: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ovf_pos_v[g], ovf_neg_v[g]}));
      a_r4_clamp_hi: assert property (@(posedge clk) disable iff (rst)
        sat_en && ovf_pos_v[g] |-> lane_raw[g*ACC_W +: ACC_W] == TOPV);
      a_r4_clamp_lo: assert property (@(posedge clk) disable iff (rst)
        sat_en && ovf_neg_v[g] |-> lane_raw[g*ACC_W +: ACC_W] == BOTV);
      // R6: zeroing of predicated-off lanes
      a_r6_zeroed: assert property (@(posedge clk) disable iff (rst)
        in_valid && zero_fill && !lane_en[g] |=> result[g*ACC_W +: ACC_W] == '0);
      // R5: merge keeps the old accumulator in active lanes
      if (g < HALF) begin : g_low
        a_r5_merge: assert property (@(posedge clk) disable iff (rst)
          in_valid && !zero_fill && !lane_en[g]
          |=> result[g*ACC_W +: ACC_W] == $past(acc_in[g*ACC_W +: ACC_W]));
      end else begin : g_high
        a_r5_merge: assert property (@(posedge clk) disable iff (rst)
          in_valid && !half_mode && !zero_fill && !lane_en[g]
          |=> result[g*ACC_W +: ACC_W] == $past(acc_in[g*ACC_W +: ACC_W]));
      end
    end
  endgenerate

endmodule

bind mixdot_acc_unit dotacc_chk #(
  .LANES(LANES),
  .ACC_W(ACC_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .half_mode(half_mode),
  .sat_en   (sat_en),
  .zero_fill(zero_fill),
  .lane_en  (lane_en),
  .acc_in   (acc_in),
  .lane_raw (lane_raw),
  .ovf_pos_v(ovf_pos_v),
  .ovf_neg_v(ovf_neg_v),
  .out_valid(out_valid),
  .result   (result)
);

// File: tb/tb_mixdot_acc_unit.sv
module tb_mixdot_acc_unit;

  localparam int CLK_PERIOD = 10;
  localparam int LN = 8;
  localparam int W  = LN * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          half_mode = 1'b0;
  logic          sat_en = 1'b0;
  logic          zero_fill = 1'b0;
  logic [LN-1:0] lane_en = '0;
  logic [W-1:0]  acc_in = '0;
  logic [W-1:0]  op_u = '0;
  logic [W-1:0]  op_s = '0;
  logic          out_valid;
  logic [W-1:0]  result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mixdot_acc_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .half_mode(half_mode),
    .sat_en(sat_en), .zero_fill(zero_fill), .lane_en(lane_en),
    .acc_in(acc_in), .op_u(op_u), .op_s(op_s),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] model_sum(logic [31:0] s, logic [31:0] a,
                                            logic [31:0] b, bit sat);
    longint tot;
    tot = longint'($signed(s));
    for (int k = 0; k < 4; k++) begin
      int ua;
      int sb;
      ua = a[8*k +: 8];
      sb = $signed(b[8*k +: 8]);
      tot += longint'(ua * sb);
    end
    if (sat && tot > 64'sd2147483647)  return 32'h7FFF_FFFF;
    if (sat && tot < -64'sd2147483648) return 32'h8000_0000;
    return tot[31:0];
  endfunction

  function automatic logic [31:0] model_lane(int j);
    bit act;
    act = (j < LN/2) || !half_mode;
    if (!act) return 32'h0;
    if (lane_en[j]) return model_sum(acc_in[32*j +: 32], op_u[32*j +: 32],
                                     op_s[32*j +: 32], sat_en);
    return zero_fill ? 32'h0 : acc_in[32*j +: 32];
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Drive one operation at a falling edge, check it at the next falling edge.
  task automatic issue(string req);
    logic [31:0] exp [LN];
    @(negedge clk);
    in_valid = 1'b1;
    for (int j = 0; j < LN; j++) exp[j] = model_lane(j);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {31'b0, out_valid}, 32'h1, "out_valid");
    for (int j = 0; j < LN; j++)
      check(req, result[32*j +: 32], exp[j], $sformatf("lane %0d", j));
  endtask

  task automatic set_ops(logic [W-1:0] s, logic [W-1:0] a, logic [W-1:0] b,
                         logic [LN-1:0] m, bit half, bit sat, bit zf);
    acc_in = s; op_u = a; op_s = b; lane_en = m;
    half_mode = half; sat_en = sat; zero_fill = zf;
  endtask

  task automatic t_reset();
    check("R10", {31'b0, out_valid}, 32'h0, "out_valid in reset");
    check("R10", result[31:0], 32'h0, "result lane 0 in reset");
    check("R10", result[W-1:W-32], 32'h0, "result top lane in reset");
  endtask

  // R1, R2: lane-distinct bytes, all lanes enabled, wrap mode
  task automatic t_basic();
    logic [W-1:0] a, b, s;
    for (int j = 0; j < LN; j++) begin
      a[32*j +: 32] = {8'(j+1), 8'(2*j+3), 8'(250-j), 8'(17*j)};
      b[32*j +: 32] = {8'(-j-1), 8'(j+5), 8'(8'h80 + j), 8'(8'h7F - j)};
      s[32*j +: 32] = 32'(1000 * j - 3000);
    end
    set_ops(s, a, b, '1, 1'b0, 1'b0, 1'b0);
    issue("R2");
    // R1: disturb only lane 3 operands; others must be unchanged
    op_u[32*3 +: 32] = 32'hFFFF_FFFF;
    op_s[32*3 +: 32] = 32'h8080_8080;
    issue("R1");
  endtask

  // R2: extreme products, unsigned 255 times signed -128
  task automatic t_extreme();
    set_ops({LN{32'h0000_0010}}, {LN{32'hFFFF_FFFF}}, {LN{32'h8080_8080}},
            '1, 1'b0, 1'b0, 1'b0);
    issue("R2");
  endtask

  // R3: wrap past the positive bound
  task automatic t_wrap();
    set_ops({LN{32'h7FFF_FFFF}}, {LN{32'hFFFF_FFFF}}, {LN{32'h7F7F_7F7F}},
            '1, 1'b0, 1'b0, 1'b0);
    issue("R3");
  endtask

  // R4: clamp high, clamp low, and a sum landing exactly on the bound
  task automatic t_sat();
    set_ops({LN{32'h7FFF_FFFF}}, {LN{32'hFFFF_FFFF}}, {LN{32'h7F7F_7F7F}},
            '1, 1'b0, 1'b1, 1'b0);
    issue("R4");
    set_ops({LN{32'h8000_0000}}, {LN{32'hFFFF_FFFF}}, {LN{32'h8080_8080}},
            '1, 1'b0, 1'b1, 1'b0);
    issue("R4");
    set_ops({LN{32'h7FFF_FFFF - 32'd129540}}, {LN{32'hFFFF_FFFF}},
            {LN{32'h7F7F_7F7F}}, '1, 1'b0, 1'b1, 1'b0);
    issue("R4");
  endtask

  // R5, R7: merge masking
  task automatic t_merge();
    set_ops({LN{32'hCAFE_0001}}, {LN{32'h0102_0304}}, {LN{32'hFF01_FE02}},
            8'hA5, 1'b0, 1'b0, 1'b0);
    issue("R5");
  endtask

  // R6, R7: zero masking
  task automatic t_zero();
    set_ops({LN{32'h1234_5678}}, {LN{32'h0A0B_0C0D}}, {LN{32'h0102_0380}},
            8'h3C, 1'b0, 1'b1, 1'b1);
    issue("R6");
    lane_en = 8'hFF;
    issue("R7");
  endtask

  // R8: half width with upper predicate bits set
  task automatic t_half();
    set_ops({LN{32'h0000_1111}}, {LN{32'h1122_3344}}, {LN{32'h0102_F0F1}},
            8'hF3, 1'b1, 1'b0, 1'b0);
    issue("R8");
    zero_fill = 1'b1;
    issue("R8");
  endtask

  // R9: idle cycle keeps result and drops out_valid
  task automatic t_hold();
    logic [W-1:0] prev;
    prev = result;
    @(negedge clk);
    op_u = ~op_u;
    acc_in = ~acc_in;
    @(negedge clk);
    check("R9", {31'b0, out_valid}, 32'h0, "out_valid after idle");
    check("R9", result[31:0], prev[31:0], "lane 0 hold");
    check("R9", result[W-1:W-32], prev[W-1:W-32], "top lane hold");
  endtask

  // R2, R3, R4: mixed patterns across every mode
  task automatic t_mix();
    for (int n = 0; n < 24; n++) begin
      logic [W-1:0] s, a, b;
      for (int j = 0; j < LN; j++) begin
        s[32*j +: 32] = $urandom;
        a[32*j +: 32] = $urandom;
        b[32*j +: 32] = $urandom;
      end
      if (n % 3 == 0) s = {LN{32'h7FFF_F000}};
      set_ops(s, a, b, 8'($urandom), 1'(n >> 2), 1'(n), 1'(n >> 1));
      issue("R2");
    end
  endtask

  // R10: reset in the middle of traffic
  task automatic t_midreset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10", {31'b0, out_valid}, 32'h0, "out_valid after reset");
    check("R10", result[63:32], 32'h0, "lane 1 after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_basic();
    t_extreme();
    t_wrap();
    t_sat();
    t_merge();
    t_zero();
    t_half();
    t_hold();
    t_mix();
    t_midreset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule